// File: doc/BRIEF.md
# Integer divide and multiply unit

This block is a multi-cycle arithmetic unit for a 32-bit core. It takes two 32-bit operands and a 4-bit operation code and returns one 32-bit result. It can return an unsigned or signed quotient, an unsigned or signed remainder, or the low or high word of the unsigned 64-bit product.

Division runs through an iterative restoring divider. The divider works on operand magnitudes for 32 steps, then spends one cycle fixing the sign. Multiplication finishes in a single cycle.

Operands enter on a valid/ready handshake. `in_ready` is high whenever no division is in flight. While it is low, `in_valid` is ignored, so a producer must hold its request until it sees ready. The output side has no back-pressure: `out_valid` is a one-cycle pulse per accepted operation, and the consumer must take `out_result` and `out_illegal` in that cycle.

Division by zero and the signed overflow case both return defined values, and neither raises a trap. An unsupported code completes at once and raises a flag.

Top module: `muldiv_unit`

## Requirements
- R1: Code 0 returns the unsigned quotient a/b and code 1 returns the unsigned remainder a%b.
- R2: Code 2 returns the signed quotient truncated toward zero. Code 3 returns the signed remainder, which takes the sign of the dividend (for example -7,2 gives -3 and -1).
- R3: For codes 2 and 3, dividend 0x80000000 with divisor 0xFFFFFFFF gives quotient 0x80000000 and remainder 0.
- R4: Code 8 returns bits 31..0 and code 9 returns bits 63..32 of the unsigned product a*b.
- R5: A zero divisor gives quotient 0xFFFFFFFF (codes 0 and 2) and the unmodified dividend as remainder (codes 1 and 3), with `out_illegal` low.
- R6: A division accepted at clock edge E has `out_valid` high for exactly the one cycle after edge E+33. `in_ready` is low from edge E+1 through edge E+33 and is high again in the cycle where `out_valid` is high.
- R7: A request presented while `in_ready` is low is ignored: it produces no `out_valid` and does not change the result of the division in flight.
- R8: Codes 8 and 9 are accepted without dropping `in_ready`, and `out_valid` is high in the cycle after the accepting edge. Back-to-back requests each get their own result.
- R9: Any code other than 0, 1, 2, 3, 8 and 9 completes in the cycle after acceptance with `out_illegal` high and `out_result` zero. For supported codes `out_illegal` is low.
- R10: While reset is held and right after it, `in_ready` is high and `out_valid` and `out_illegal` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit idle, request will be taken |
| in_op | input | 4 | Operation code |
| in_a | input | 32 | Dividend / multiplicand |
| in_b | input | 32 | Divisor / multiplier |
| out_valid | output | 1 | One-cycle completion pulse |
| out_result | output | 32 | Result, valid with out_valid |
| out_illegal | output | 1 | Unsupported code, valid with out_valid |

## Verification
The checker watches the handshake timing on every cycle: the busy window after a division is exactly 33 cycles long, the completion pulse never appears while busy, a multiply or unsupported code completes on the next cycle, and the illegal flag never appears without `out_valid`. The arithmetic itself cannot be checked that way. Quotient, remainder and product values, the overflow and zero-divisor conventions, and the fact that a request made while busy leaves the pending result untouched are shown only by the bench scenarios. Those scenarios compare the unit's output against values the bench computes itself.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  localparam int OP_W = 4;

  localparam logic [OP_W-1:0] OP_DIVU  = 4'd0;
  localparam logic [OP_W-1:0] OP_REMU  = 4'd1;
  localparam logic [OP_W-1:0] OP_DIVS  = 4'd2;
  localparam logic [OP_W-1:0] OP_REMS  = 4'd3;
  localparam logic [OP_W-1:0] OP_MULLO = 4'd8;
  localparam logic [OP_W-1:0] OP_MULHI = 4'd9;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIX} state_e;

  function automatic logic is_div(input logic [OP_W-1:0] op);
    return op[OP_W-1:2] == '0;
  endfunction

  function automatic logic is_mul(input logic [OP_W-1:0] op);
    return (op == OP_MULLO) || (op == OP_MULHI);
  endfunction
endpackage

// File: rtl/muldiv_divider.sv
module muldiv_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder
);
  logic [W-1:0] rem_q, quo_q, dvs_q;
  logic [W:0]   shifted, diff;
  logic         fits;

  always_comb begin
    shifted = {rem_q, quo_q[W-1]};
    diff    = shifted - {1'b0, dvs_q};
    fits    = ~diff[W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
    end else if (load) begin
      rem_q <= '0;
      quo_q <= dividend;
      dvs_q <= divisor;
    end else if (step) begin
      rem_q <= fits ? diff[W-1:0] : shifted[W-1:0];
      quo_q <= {quo_q[W-2:0], fits};
    end
  end

  assign quotient  = quo_q;
  assign remainder = rem_q;
endmodule

// File: rtl/muldiv_multiplier.sv
module muldiv_multiplier #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] lo,
  output logic [W-1:0] hi
);
  logic [2*W-1:0] prod;

  always_comb begin
    prod = {{W{1'b0}}, a} * {{W{1'b0}}, b};
    lo   = prod[W-1:0];
    hi   = prod[2*W-1:W];
  end
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [OP_W-1:0] in_op,
  input  logic [W-1:0]    in_a,
  input  logic [W-1:0]    in_b,
  output logic            out_valid,
  output logic [W-1:0]    out_result,
  output logic            out_illegal
);
  localparam int ITER = W;
  localparam int CW   = $clog2(ITER);

  state_e          state;
  logic [CW-1:0]   cnt_q;
  logic [OP_W-1:0] op_q;
  logic [W-1:0]    a_q;
  logic            qneg_q, rneg_q, bzero_q;

  logic            accept, take_div, signed_op;
  logic [W-1:0]    mag_a, mag_b, quo, rem, mul_lo, mul_hi, fix_result;

  assign in_ready  = (state == ST_IDLE);
  assign accept    = in_valid && in_ready;
  assign take_div  = accept && is_div(in_op);
  assign signed_op = in_op[1];

  always_comb begin
    mag_a = (signed_op && in_a[W-1]) ? -in_a : in_a;
    mag_b = (signed_op && in_b[W-1]) ? -in_b : in_b;
  end

  muldiv_divider #(.W(W)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (take_div),
    .step      (state == ST_RUN),
    .dividend  (mag_a),
    .divisor   (mag_b),
    .quotient  (quo),
    .remainder (rem)
  );

  muldiv_multiplier #(.W(W)) u_mul (
    .a  (in_a),
    .b  (in_b),
    .lo (mul_lo),
    .hi (mul_hi)
  );

  always_comb begin
    unique case (op_q)
      OP_DIVU: fix_result = quo;
      OP_REMU: fix_result = rem;
      OP_DIVS: fix_result = qneg_q ? -quo : quo;
      OP_REMS: fix_result = rneg_q ? -rem : rem;
      default: fix_result = '0;
    endcase
    if (bzero_q) fix_result = op_q[0] ? a_q : '1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      cnt_q       <= '0;
      op_q        <= '0;
      a_q         <= '0;
      qneg_q      <= 1'b0;
      rneg_q      <= 1'b0;
      bzero_q     <= 1'b0;
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_illegal <= 1'b0;
    end else begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (take_div) begin
            state   <= ST_RUN;
            cnt_q   <= '0;
            op_q    <= in_op;
            a_q     <= in_a;
            qneg_q  <= signed_op && (in_a[W-1] ^ in_b[W-1]);
            rneg_q  <= signed_op && in_a[W-1];
            bzero_q <= (in_b == '0);
          end else if (accept) begin
            out_valid <= 1'b1;
            if (is_mul(in_op)) begin
              out_result <= (in_op == OP_MULHI) ? mul_hi : mul_lo;
            end else begin
              out_result  <= '0;
              out_illegal <= 1'b1;
            end
          end
        end
        ST_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CW'(ITER - 1)) state <= ST_FIX;
        end
        ST_FIX: begin
          out_valid  <= 1'b1;
          out_result <= fix_result;
          state      <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/muldiv_unit_chk.sv
module muldiv_unit_chk #(
  parameter int W = 32
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [3:0] in_op,
  input logic       out_valid,
  input logic       out_illegal
);
  localparam int BUSY = W + 1;
  localparam int BW   = $clog2(BUSY + 1) + 1;

  logic [BW-1:0] busy_cnt;
  logic          acc, acc_div, acc_mul, acc_bad;

  assign acc     = in_valid && in_ready;
  assign acc_div = acc && (in_op <= 4'd3);
  assign acc_mul = acc && (in_op == 4'd8 || in_op == 4'd9);
  assign acc_bad = acc && !(in_op <= 4'd3) && !(in_op == 4'd8 || in_op == 4'd9);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_cnt <= '0;
    else if (!in_ready) busy_cnt <= busy_cnt + 1'b1;
    else busy_cnt <= '0;
  end

  p_busy_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !$past(in_ready)) |-> (busy_cnt == BW'(BUSY)));

  p_div_goes_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_div |=> (!in_ready && !out_valid));

  p_done_when_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_ready);

  p_mul_next_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_mul |=> (out_valid && !out_illegal && in_ready));

  p_bad_code_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_bad |=> (out_valid && out_illegal));

  p_flag_needs_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> out_valid);

  always_comb begin
    if (!rst_n) begin
      a_reset_r10: assert (in_ready && !out_valid && !out_illegal);
    end
  end
endmodule

bind muldiv_unit muldiv_unit_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_op       (in_op),
  .out_valid   (out_valid),
  .out_illegal (out_illegal)
);

// File: tb/muldiv_unit_test.sv
module muldiv_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_op = '0;
  logic [31:0] in_a = '0;
  logic [31:0] in_b = '0;
  logic        out_valid;
  logic [31:0] out_result;
  logic        out_illegal;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  muldiv_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
    .out_result(out_result), .out_illegal(out_illegal)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_div(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
    if (b == 0) return op[0] ? a : 32'hFFFF_FFFF;
    if (op[1] && a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return op[0] ? 32'h0 : 32'h8000_0000;
    case (op)
      4'd0: return a / b;
      4'd1: return a % b;
      4'd2: return $signed(a) / $signed(b);
      default: return $signed(a) % $signed(b);
    endcase
  endfunction

  function automatic logic [63:0] ref_mul(input logic [31:0] a, input logic [31:0] b);
    return {32'h0, a} * {32'h0, b};
  endfunction

  task automatic issue(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
    in_op = op; in_a = a; in_b = b; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_div(input string req, input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
    int early = 0;
    issue(op, a, b);
    chk("R6 busy after accept", {31'h0, in_ready}, 32'h0);
    for (int k = 1; k < 33; k++) begin
      @(negedge clk);
      if (out_valid || in_ready) early++;
    end
    chk("R6 no early done", early, 0);
    @(negedge clk);
    chk("R6 done at 33", {30'h0, out_valid, in_ready}, 32'h3);
    chk(req, out_result, ref_div(op, a, b));
    chk("R5 R1 R2 flag low", {31'h0, out_illegal}, 32'h0);
    @(negedge clk);
    chk("R6 single pulse", {31'h0, out_valid}, 32'h0);
  endtask

  task automatic run_fast(input string req, input logic [3:0] op, input logic [31:0] a,
                          input logic [31:0] b, input logic [31:0] exp, input logic ill);
    issue(op, a, b);
    chk({req, " valid+ready"}, {30'h0, out_valid, in_ready}, 32'h3);
    chk({req, " flag"}, {31'h0, out_illegal}, {31'h0, ill});
    chk(req, out_result, exp);
  endtask

  task automatic t_reset;
    chk("R10 reset held", {29'h0, in_ready, out_valid, out_illegal}, 32'h4);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R10 after reset", {29'h0, in_ready, out_valid, out_illegal}, 32'h4);
  endtask

  task automatic t_unsigned;
    run_div("R1 divu 100/7", 4'd0, 32'd100, 32'd7);
    run_div("R1 remu 100/7", 4'd1, 32'd100, 32'd7);
    run_div("R1 divu big/3", 4'd0, 32'hFFFF_FFFF, 32'd3);
    run_div("R1 remu 5/9", 4'd1, 32'd5, 32'd9);
    run_div("R1 remu big/large", 4'd1, 32'hF000_0001, 32'h8000_0000);
  endtask

  task automatic t_signed;
    run_div("R2 divs -7/2", 4'd2, -32'sd7, 32'd2);
    run_div("R2 rems -7/2", 4'd3, -32'sd7, 32'd2);
    run_div("R2 divs 7/-2", 4'd2, 32'd7, -32'sd2);
    run_div("R2 rems 7/-2", 4'd3, 32'd7, -32'sd2);
    run_div("R2 divs -7/-2", 4'd2, -32'sd7, -32'sd2);
    run_div("R2 rems -7/-2", 4'd3, -32'sd7, -32'sd2);
  endtask

  task automatic t_overflow;
    run_div("R3 divs min/-1", 4'd2, 32'h8000_0000, 32'hFFFF_FFFF);
    run_div("R3 rems min/-1", 4'd3, 32'h8000_0000, 32'hFFFF_FFFF);
  endtask

  task automatic t_divzero;
    run_div("R5 divu by 0", 4'd0, 32'h1234_5678, 32'd0);
    run_div("R5 remu by 0", 4'd1, 32'h1234_5678, 32'd0);
    run_div("R5 divs -9 by 0", 4'd2, -32'sd9, 32'd0);
    run_div("R5 rems -9 by 0", 4'd3, -32'sd9, 32'd0);
  endtask

  task automatic t_mul;
    logic [63:0] p;
    p = ref_mul(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run_fast("R4 mullo max", 4'd8, 32'hFFFF_FFFF, 32'hFFFF_FFFF, p[31:0], 1'b0);
    run_fast("R4 mulhi max", 4'd9, 32'hFFFF_FFFF, 32'hFFFF_FFFF, p[63:32], 1'b0);
    p = ref_mul(32'h8000_0000, 32'd6);
    run_fast("R4 mulhi 2^31*6", 4'd9, 32'h8000_0000, 32'd6, p[63:32], 1'b0);
    run_fast("R4 mullo 123*45", 4'd8, 32'd123, 32'd45, 32'd5535, 1'b0);
  endtask

  task automatic t_back_to_back;
    logic [63:0] p;
    p = ref_mul(32'hDEAD_BEEF, 32'h0001_0003);
    in_op = 4'd8; in_a = 32'd1000; in_b = 32'd1000; in_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R8 first of pair", out_result, 32'd1000000);
    chk("R8 ready kept", {30'h0, out_valid, in_ready}, 32'h3);
    in_op = 4'd9; in_a = 32'hDEAD_BEEF; in_b = 32'h0001_0003;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    chk("R8 second of pair", out_result, p[63:32]);
    chk("R8 second valid", {31'h0, out_valid}, 32'h1);
    @(negedge clk);
    chk("R8 pulse ends", {31'h0, out_valid}, 32'h0);
  endtask

  task automatic t_illegal;
    run_fast("R9 code 4", 4'd4, 32'd5, 32'd6, 32'h0, 1'b1);
    run_fast("R9 code 15", 4'd15, 32'hFFFF_FFFF, 32'd1, 32'h0, 1'b1);
    run_fast("R9 code 10", 4'd10, 32'd3, 32'd3, 32'h0, 1'b1);
  endtask

  task automatic t_busy_ignore;
    int extra = 0;
    issue(4'd0, 32'd1000, 32'd10);
    in_op = 4'd8; in_a = 32'd7; in_b = 32'd7; in_valid = 1'b1;
    for (int k = 1; k < 33; k++) begin
      @(negedge clk);
      if (k == 8) begin in_op = 4'd1; in_a = 32'd3; in_b = 32'd2; end
      if (k == 20) in_valid = 1'b0;
      if (out_valid) extra++;
    end
    chk("R7 no output while busy", extra, 0);
    @(negedge clk);
    chk("R7 pending result intact", out_result, 32'd100);
    chk("R7 done once", {31'h0, out_valid}, 32'h1);
    @(negedge clk);
    chk("R7 no extra completion", {31'h0, out_valid}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL R6 watchdog actual=hung expected=complete");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_unsigned();
    t_signed();
    t_overflow();
    t_divzero();
    t_mul();
    t_back_to_back();
    t_illegal();
    t_busy_ignore();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule